// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Flags

This block watches the eight input pins of one general-purpose I/O port and turns selected transitions into interrupt requests. Each pin first passes through a two-stage synchroniser. An edge detector then compares the synchronised level with its value one cycle earlier. A per-pin select bit chooses whether a rising or a falling transition counts as that pin's event. An event sets the pin's sticky flag. The flag stays set until software clears it by writing a 1 to it.

A single request line goes to the processor side. It is gated at three levels: the pin's own enable, an enable for the whole port as an interrupt source, and a global enable. Software reaches the enables, the edge selects, the flags and a masked status word through a plain register bus. A write takes effect on the clock edge at which the write strobe is high. A read is combinational from the address. There is no valid/ready handshake, because the bus carries only control and status, not a data stream.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0 and `irq_req` is 0. Pins that are already high when reset is released produce no flag.
- R2: The pin enable register at address 0 holds one bit per pin. Each bit can be written and read back independently.
- R3: When a pin's edge-select bit is 0, a 0-to-1 change on that pin sets its flag (flag register bit n for pin n) three clock edges after the pin changes. A 1-to-0 change on that pin sets nothing.
- R4: When a pin's edge-select bit is 1, a 1-to-0 change sets the pin's flag and a 0-to-1 change sets nothing.
- R5: A qualifying edge sets the flag even when that pin's enable bit is 0. In that case `irq_req` stays 0.
- R6: The flags at address 2 stay set until software clears them. Writing 1 to a flag bit at address 2 clears that bit. Writing 0 to a flag bit leaves it unchanged.
- R7: If a qualifying edge and a write-1-to-clear for the same pin fall on the same clock edge, the flag ends up set.
- R8: `irq_req` is 1 only when, for at least one pin, the flag and the pin enable are both 1, and the port source enable and the global enable are also both 1.
- R9: Address 3 reads the flags ANDed bit by bit with the pin enables.
- R10: Address 1 holds the edge-select bits (read/write). Address 4 bit 0 is the port source enable and address 4 bit 1 is the global enable (read/write). Other bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Asynchronous port pin levels |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| irq_req | output | 1 | Interrupt request to the processor side |

## Verification
The hardest case to reach is the collision of R7, where a clear and a new edge land on the same clock edge. The bench first sets the pin's flag with an earlier edge. It then changes the pin again and holds the write-1-to-clear until the negative edge after the second register stage has captured the new level. The write therefore takes effect on exactly the edge at which the flag is set again. The bench also releases reset with pins already high, to show that the synchroniser warm-up raises no false flag.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PIN_EN   = 3'd0,
    REG_EDGE_SEL = 3'd1,
    REG_FLAGS    = 3'd2,
    REG_STATUS   = 3'd3,
    REG_CTRL     = 3'd4
  } reg_addr_e;

  localparam int CTRL_SRC_BIT = 0;
  localparam int CTRL_GIE_BIT = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic         primed
);
  localparam int CW = $clog2(STAGES + 2);
  localparam logic [CW-1:0] PRIME_AT = CW'(STAGES + 1);

  logic [W-1:0] stage_q [STAGES];
  logic [CW-1:0] warm_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
  assign primed   = (warm_q == PRIME_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (!primed) warm_q <= warm_q + CW'(1);
  end

  a_r1_primed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic         armed,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] flags,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall;

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign evt  = {W{armed}} & ((~fall_sel & rise) | (fall_sel & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= level;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags[i] <= 1'b0;
        else if (evt[i]) flags[i] <= 1'b1;
        else if (clr[i]) flags[i] <= 1'b0;
      end

      a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !clr[i]) |=> flags[i]);
      a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !evt[i]) |=> !flags[i]);
      a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flags[i]);
      a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !evt[i]);
    end
  endgenerate
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      flags,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      pin_en,
  output logic [W-1:0]      fall_sel,
  output logic              src_en,
  output logic              gie,
  output logic [W-1:0]      clr
);
  logic [W-1:0] ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en   <= '0;
      fall_sel <= '0;
      src_en   <= 1'b0;
      gie      <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        REG_PIN_EN:   pin_en   <= wdata;
        REG_EDGE_SEL: fall_sel <= wdata;
        REG_CTRL: begin
          src_en <= wdata[CTRL_SRC_BIT];
          gie    <= wdata[CTRL_GIE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign clr = (wr_en && addr == REG_FLAGS) ? wdata : '0;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_SRC_BIT] = src_en;
    ctrl_word[CTRL_GIE_BIT] = gie;
    case (addr)
      REG_PIN_EN:   rdata = pin_en;
      REG_EDGE_SEL: rdata = fall_sel;
      REG_FLAGS:    rdata = flags;
      REG_STATUS:   rdata = flags & pin_en;
      REG_CTRL:     rdata = ctrl_word;
      default:      rdata = '0;
    endcase
  end

  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_PIN_EN) |=> (pin_en == $past(wdata)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_req
);
  logic [NPINS-1:0] level, flags, evt, pin_en, fall_sel, clr;
  logic             armed, src_en, gie;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in),
    .sync_out(level), .primed(armed)
  );

  gpio_edge_flag #(.W(NPINS)) u_flag (
    .clk(clk), .rst_n(rst_n), .level(level), .armed(armed),
    .fall_sel(fall_sel), .clr(clr), .flags(flags), .evt(evt)
  );

  gpio_irq_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .flags(flags), .rdata(bus_rdata),
    .pin_en(pin_en), .fall_sel(fall_sel), .src_en(src_en), .gie(gie),
    .clr(clr)
  );

  assign irq_req = gie & src_en & (|(flags & pin_en));

  a_r8_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req);
  a_r8_src_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en |-> !irq_req);
  a_r5_masked_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_en == '0) |-> !irq_req);
endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = 8'h81;
  logic       bus_wr_en = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] addr;
    logic [7:0] data;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req)
  );

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (bus_rdata !== e.data || irq_req !== e.irq) begin
          failures++;
          $display("FAIL %s addr=%0d rdata=%02h irq=%0b expected rdata=%02h irq=%0b",
                   e.tag, e.addr, bus_rdata, irq_req, e.data, e.irq);
        end
      end
    end
  end

  // Driver tasks; all are called at a negative edge and return at the next one.
  task automatic expect_reg(input logic [2:0] a, input logic [7:0] d,
                            input logic irq, input string tag);
    exp_t e;
    bus_addr = a;
    e.addr = a; e.data = d; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pins(input logic [7:0] v);
    pin_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    // R1: pins were high through reset and warm-up; no flags, all zeros
    expect_reg(3'd0, 8'h00, 1'b0, "R1 pin enable reset");
    expect_reg(3'd1, 8'h00, 1'b0, "R1 edge select reset");
    expect_reg(3'd2, 8'h00, 1'b0, "R1 flags reset, pins high");
    expect_reg(3'd4, 8'h00, 1'b0, "R1 control reset");
    // R2 / R10 register access
    wr(3'd0, 8'h5A);
    expect_reg(3'd0, 8'h5A, 1'b0, "R2 pin enable readback");
    wr(3'd0, 8'hA5);
    expect_reg(3'd0, 8'hA5, 1'b0, "R2 pin enable bits independent");
    wr(3'd1, 8'hF0);
    expect_reg(3'd1, 8'hF0, 1'b0, "R10 edge select readback");
    wr(3'd4, 8'hFF);
    expect_reg(3'd4, 8'h03, 1'b0, "R10 control readback, upper bits 0");
    expect_reg(3'd6, 8'h00, 1'b0, "R10 unmapped reads 0");
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
    // R3 rising on pin1, exact timing; R5 flag with enable 0
    pins(8'h83);
    idle(1);
    expect_reg(3'd2, 8'h00, 1'b0, "R3 flag not yet after two edges");
    expect_reg(3'd2, 8'h02, 1'b0, "R3 rising flag after three edges");
    expect_reg(3'd2, 8'h02, 1'b0, "R5 flag set while disabled, no request");
    // R3 falling on pin0 with rising select sets nothing
    pins(8'h82);
    idle(4);
    expect_reg(3'd2, 8'h02, 1'b0, "R3 opposite edge ignored");
    // R4 falling select on upper nibble
    wr(3'd1, 8'hF0);
    pins(8'h02);
    idle(4);
    expect_reg(3'd2, 8'h82, 1'b0, "R4 falling edge sets flag");
    pins(8'h12);
    idle(4);
    expect_reg(3'd2, 8'h82, 1'b0, "R4 rising edge ignored on falling select");
    // R9 status
    wr(3'd0, 8'h80);
    expect_reg(3'd3, 8'h80, 1'b0, "R9 status masked by enables");
    // R8 gating
    wr(3'd4, 8'h01);
    expect_reg(3'd4, 8'h01, 1'b0, "R8 source only, no request");
    wr(3'd4, 8'h02);
    expect_reg(3'd4, 8'h02, 1'b0, "R8 global only, no request");
    wr(3'd4, 8'h03);
    expect_reg(3'd4, 8'h03, 1'b1, "R8 all gates open");
    wr(3'd0, 8'h04);
    expect_reg(3'd3, 8'h00, 1'b0, "R8 enabled pin has no flag");
    wr(3'd0, 8'h80);
    expect_reg(3'd3, 8'h80, 1'b1, "R8 request restored");
    // R6 write-1-to-clear
    wr(3'd2, 8'h00);
    expect_reg(3'd2, 8'h82, 1'b1, "R6 writing 0 keeps flags");
    wr(3'd2, 8'h02);
    expect_reg(3'd2, 8'h80, 1'b1, "R6 clear one flag");
    wr(3'd2, 8'h80);
    expect_reg(3'd2, 8'h00, 1'b0, "R6 clear drops request");
    // R7 collision on pin2 (rising select)
    pins(8'h16);
    idle(4);
    expect_reg(3'd2, 8'h04, 1'b0, "R7 setup flag");
    pins(8'h12);
    idle(4);
    pins(8'h16);          // after posedge 1
    idle(1);              // after posedge 2
    wr(3'd2, 8'h04);      // clear lands on posedge 3 with the new edge
    expect_reg(3'd2, 8'h04, 1'b0, "R7 set wins over clear");
    wr(3'd2, 8'h04);
    expect_reg(3'd2, 8'h00, 1'b0, "R7 later clear works");
    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule